// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block sits beside a processor's memory port and judges every access against eight programmable protection regions. Each region is a naturally aligned power-of-two window with its own permission code for privileged and user software, an execute-never flag, eight sub-region hole bits and an enable bit. The decision is combinational, so the access can be stopped in the cycle it is issued. A violation is also captured in a register one cycle later together with the offending address, ready for the fault handler.

A small synchronous register port programs a control word and, per region, a base word and an attribute word. The control word turns the whole checker on, lets privileged code fall back to the default map where no region matches, and decides whether checking stays active while the processor runs in hard-fault or NMI context.

Top module: `mem_guard`

## Requirements
- R1: While control bit 0 (unit enable) is 0, every access is allowed and `fault_valid` never rises.
- R2: Attribute bits [5:1] hold a size code N giving a window of 2^(N+1) bytes aligned to its size; an address matches when its bits above bit N equal the base. Codes below 4 never match.
- R3: Attribute bits [26:24] hold the permission code: 0 none; 1 privileged read/write only; 2 privileged read/write, user read; 3 read/write for both; 5 privileged read only; 6 read only for both; 4 and 7 none. `acc_kind` encodes 0 read, 1 write, 2 instruction fetch; a fetch needs read permission.
- R4: With attribute bit 28 (execute-never) set, an instruction fetch decided by that region faults while reads in it may still succeed.
- R5: Attribute bits [15:8] disable the eight equal sub-regions 0..7 of a window of 256 bytes or more; an address in a disabled sub-region does not match. For smaller windows these bits have no effect.
- R6: When several enabled regions match, the one with the highest index decides the outcome and is reported.
- R7: An access matching no region is allowed only if it is privileged and control bit 1 (privileged default map) is set; every other unmatched access faults.
- R8: An access flagged as fault context is allowed without checking unless control bit 2 (check in fault context) is set.
- R9: Attribute bit 0 enables a region; a disabled region never matches and keeps its other fields, which read back unchanged.
- R10: One cycle after a valid access is refused, `fault_valid` is 1 and `fault_addr` holds its address; `fault_addr` keeps that value until the next fault, and an invalid or allowed access leaves `fault_valid` at 0.
- R11: Register port: `cfg_addr[4]`=0 selects the control word (bits [2:0]); otherwise `cfg_addr[3:1]` is the region and `cfg_addr[0]` picks base (0) or attribute (1). Base reads back with bits [4:0] zero, attributes with only defined fields, control with only bits [2:0]. All read 0 after reset.
- R12: `acc_hit` shows whether any enabled region matches and `acc_region` gives the deciding region index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_priv | input | 1 | Access is privileged |
| acc_fault_ctx | input | 1 | Processor is in hard-fault or NMI context |
| acc_allow | output | 1 | Access permitted (combinational) |
| acc_hit | output | 1 | Some enabled region matches |
| acc_region | output | 3 | Index of the deciding region |
| fault_valid | output | 1 | Registered fault pulse |
| fault_addr | output | 32 | Address of the most recent refused access |

## Verification
The assertions watch on every cycle that a disabled unit allows everything, that the reported region is the highest matching one, that unprivileged misses and execute-never fetches are refused, and that each refused access produces a registered fault with its address while idle cycles produce none. Only the directed scenarios show the address arithmetic: window sizes and alignment, the rejection of small size codes, sub-region holes and their 256-byte threshold, the full permission table, the default-map and fault-context control bits, and register readback masking.

// File: rtl/mguard_pkg.sv
package mguard_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  // control word, bit 0 = unit enable, bit 1 = privileged default, bit 2 = check in fault context
  typedef struct packed {
    logic ctx_chk;
    logic priv_def;
    logic unit_en;
  } ctl_t;

  typedef struct packed {
    logic       xn;
    logic [2:0] ap;
    logic [7:0] srd;
    logic [4:0] size;
    logic       en;
  } rgn_attr_t;

  function automatic logic [DATA_W-1:0] attr_pack(rgn_attr_t a);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[0]     = a.en;
    w[5:1]   = a.size;
    w[15:8]  = a.srd;
    w[26:24] = a.ap;
    w[28]    = a.xn;
    return w;
  endfunction

  function automatic rgn_attr_t attr_unpack(logic [DATA_W-1:0] w);
    rgn_attr_t a;
    a.en   = w[0];
    a.size = w[5:1];
    a.srd  = w[15:8];
    a.ap   = w[26:24];
    a.xn   = w[28];
    return a;
  endfunction

  // permission decode: priv level and write intent against the code
  function automatic logic perm_ok(logic [2:0] ap, logic priv, logic wr);
    logic ok;
    case (ap)
      3'd1:    ok = priv;
      3'd2:    ok = priv | ~wr;
      3'd3:    ok = 1'b1;
      3'd5:    ok = priv & ~wr;
      3'd6:    ok = ~wr;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/mguard_cfg_regs.sv
module mguard_cfg_regs
  import mguard_pkg::*;
#(
  parameter int NUM_RGN   = 8,
  parameter int ADDR_W    = 32,
  parameter int MIN_SHIFT = 5,
  parameter int IDX_W     = $clog2(NUM_RGN),
  parameter int CA_W      = IDX_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CA_W-1:0]         addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  output ctl_t                    ctl,
  output logic [ADDR_W-1:MIN_SHIFT] base [NUM_RGN],
  output rgn_attr_t               attr [NUM_RGN]
);

  localparam int BASE_W = ADDR_W - MIN_SHIFT;

  logic             tbl_sel;
  logic [IDX_W-1:0] ridx;
  logic             ctl_en;
  ctl_t             ctl_d, ctl_q;

  assign tbl_sel = addr[CA_W-1];
  assign ridx    = addr[CA_W-2:1];

  // control word
  always_comb begin
    ctl_en = wr_en & ~tbl_sel;
    ctl_d  = ctl_t'(wdata[2:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;

  // region table
  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    logic              base_en, attr_en;
    logic [BASE_W-1:0] base_d, base_q;
    rgn_attr_t         attr_d, attr_q;

    always_comb begin
      base_en = wr_en & tbl_sel & (ridx == IDX_W'(g)) & ~addr[0];
      attr_en = wr_en & tbl_sel & (ridx == IDX_W'(g)) &  addr[0];
      base_d  = wdata[ADDR_W-1:MIN_SHIFT];
      attr_d  = attr_unpack(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       base_q <= '0;
      else if (base_en) base_q <= base_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       attr_q <= '0;
      else if (attr_en) attr_q <= attr_d;
    end

    assign base[g] = base_q;
    assign attr[g] = attr_q;
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (!tbl_sel)     rdata[2:0] = ctl_q;
    else if (addr[0]) rdata = attr_pack(attr[ridx]);
    else              rdata[ADDR_W-1:0] = {base[ridx], {MIN_SHIFT{1'b0}}};
  end

endmodule

// File: rtl/mguard_rgn_match.sv
module mguard_rgn_match
  import mguard_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MIN_SHIFT = 5
) (
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic [ADDR_W-1:MIN_SHIFT] base,
  input  rgn_attr_t                 attr,
  output logic                      hit
);

  localparam int          BW       = $clog2(ADDR_W) + 1;
  localparam logic [4:0]  SIZE_MIN = 5'd4;  // 32-byte window
  localparam logic [4:0]  SUB_MIN  = 5'd7;  // 256-byte window

  logic [ADDR_W-1:0] base_full;
  logic [ADDR_W-1:0] cmp_mask;
  logic [ADDR_W-1:0] shifted;
  logic [2:0]        sub_idx;
  logic              size_ok, range_hit, sub_on, sub_hole;

  assign base_full = {base, {MIN_SHIFT{1'b0}}};

  // bit b takes part in the compare when it lies above the size code
  for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
    assign cmp_mask[b] = (BW'(b) > BW'(attr.size));
  end

  always_comb begin
    size_ok   = attr.size >= SIZE_MIN;
    range_hit = ((acc_addr ^ base_full) & cmp_mask) == '0;
    shifted   = acc_addr >> (attr.size - 5'd2);
    sub_idx   = shifted[2:0];
    sub_on    = attr.size >= SUB_MIN;
    sub_hole  = sub_on & attr.srd[sub_idx];
    hit       = attr.en & size_ok & range_hit & ~sub_hole;
  end

  logic unused_shift;
  assign unused_shift = ^shifted[ADDR_W-1:3];

endmodule

// File: rtl/mguard_decide.sv
module mguard_decide
  import mguard_pkg::*;
#(
  parameter int NUM_RGN = 8,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = $clog2(NUM_RGN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [1:0]         acc_kind,
  input  logic               acc_priv,
  input  logic               acc_fault_ctx,
  input  ctl_t               ctl,
  input  logic [NUM_RGN-1:0] hit_vec,
  input  rgn_attr_t          attr [NUM_RGN],
  output logic               allow,
  output logic               any_hit,
  output logic [IDX_W-1:0]   win_idx,
  output logic               fault_valid,
  output logic [ADDR_W-1:0]  fault_addr
);

  rgn_attr_t   win;
  logic        bypass, is_wr, is_fx;
  logic        flt_d, flt_q;
  logic [ADDR_W-1:0] fad_q;

  // highest-numbered matching region wins
  always_comb begin
    win_idx = '0;
    any_hit = 1'b0;
    for (int i = 0; i < NUM_RGN; i++) begin
      if (hit_vec[i]) begin
        win_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  always_comb begin
    win    = attr[win_idx];
    is_wr  = acc_kind_e'(acc_kind) == ACC_WRITE;
    is_fx  = acc_kind_e'(acc_kind) == ACC_FETCH;
    bypass = ~ctl.unit_en | (acc_fault_ctx & ~ctl.ctx_chk);
    if (bypass)        allow = 1'b1;
    else if (!any_hit) allow = acc_priv & ctl.priv_def;
    else               allow = perm_ok(win.ap, acc_priv, is_wr) & ~(is_fx & win.xn);
    flt_d = acc_valid & ~allow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flt_q <= 1'b0;
    else        flt_q <= flt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fad_q <= '0;
    else if (flt_d) fad_q <= acc_addr;
  end

  assign fault_valid = flt_q;
  assign fault_addr  = fad_q;

  // R1: disabled unit lets everything through
  p_off_allows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.unit_en |-> allow);

  // R6: reported region is a matching one and no higher one matches
  p_top_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ((hit_vec >> win_idx) == NUM_RGN'(1)));

  // R7: unmatched user access is refused while checking is active
  p_user_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.unit_en && !acc_fault_ctx && !acc_priv && hit_vec == '0) |-> !allow);

  // R4: fetch from an execute-never winner is refused
  p_xn_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.unit_en && !acc_fault_ctx && hit_vec != '0 && attr[win_idx].xn
     && acc_kind == 2'd2) |-> !allow);

  // R10: refused access is reported next cycle with its address
  p_fault_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !allow) |=> (fault_valid && fault_addr == $past(acc_addr)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !fault_valid);

endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mguard_pkg::*;
#(
  parameter int NUM_RGN   = 8,
  parameter int ADDR_W    = 32,
  parameter int MIN_SHIFT = 5,
  localparam int IDX_W    = $clog2(NUM_RGN),
  localparam int CA_W     = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CA_W-1:0]   cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic              acc_priv,
  input  logic              acc_fault_ctx,
  output logic              acc_allow,
  output logic              acc_hit,
  output logic [IDX_W-1:0]  acc_region,
  output logic              fault_valid,
  output logic [ADDR_W-1:0] fault_addr
);

  ctl_t                      ctl;
  logic [ADDR_W-1:MIN_SHIFT] base [NUM_RGN];
  rgn_attr_t                 attr [NUM_RGN];
  logic [NUM_RGN-1:0]        hit_vec;

  mguard_cfg_regs #(
    .NUM_RGN  (NUM_RGN),
    .ADDR_W   (ADDR_W),
    .MIN_SHIFT(MIN_SHIFT),
    .IDX_W    (IDX_W),
    .CA_W     (CA_W)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(cfg_wr),
    .addr (cfg_addr),
    .wdata(cfg_wdata),
    .rdata(cfg_rdata),
    .ctl  (ctl),
    .base (base),
    .attr (attr)
  );

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_match
    mguard_rgn_match #(
      .ADDR_W   (ADDR_W),
      .MIN_SHIFT(MIN_SHIFT)
    ) u_match (
      .acc_addr(acc_addr),
      .base    (base[g]),
      .attr    (attr[g]),
      .hit     (hit_vec[g])
    );
  end

  mguard_decide #(
    .NUM_RGN(NUM_RGN),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_decide (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_addr     (acc_addr),
    .acc_kind     (acc_kind),
    .acc_priv     (acc_priv),
    .acc_fault_ctx(acc_fault_ctx),
    .ctl          (ctl),
    .hit_vec      (hit_vec),
    .attr         (attr),
    .allow        (acc_allow),
    .any_hit      (acc_hit),
    .win_idx      (acc_region),
    .fault_valid  (fault_valid),
    .fault_addr   (fault_addr)
  );

endmodule

// File: tb/sim_mem_guard.sv
module sim_mem_guard;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        cfg_wr;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic [1:0]  acc_kind;
  logic        acc_priv, acc_fault_ctx;
  logic        acc_allow, acc_hit;
  logic [2:0]  acc_region;
  logic        fault_valid;
  logic [31:0] fault_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, FX = 2'd2;

  mem_guard u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_attr(bit en, int sz, int ap, bit xn, logic [7:0] srd);
    logic [31:0] w;
    w = 32'(en) | (32'(sz) << 1) | (32'(srd) << 8) | (32'(ap) << 24) | (32'(xn) << 28);
    return w;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1 chk(tag, cfg_rdata, exp);
  endtask

  task automatic set_rgn(input int idx, input logic [31:0] b, input logic [31:0] at);
    wr(5'(16 + 2*idx), b);
    wr(5'(17 + 2*idx), at);
  endtask

  // ei/eh < 0 skip that field
  task automatic probe(input logic [31:0] a, input logic [1:0] k, input bit p, input bit c,
                       input bit ea, input int eh, input int ei, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_priv = p; acc_fault_ctx = c;
    #1;
    chk({tag, " allow"}, 32'(acc_allow), 32'(ea));
    if (eh >= 0) chk({tag, " hit"}, 32'(acc_hit), 32'(eh));
    if (ei >= 0) chk({tag, " region"}, 32'(acc_region), 32'(ei));
    @(negedge clk);
    acc_valid = 1'b0;
    #1;
    chk({tag, " fault_valid R10"}, 32'(fault_valid), 32'(!ea));
    if (!ea) chk({tag, " fault_addr R10"}, fault_addr, a);
  endtask

  task automatic t_reset;
    chk("R11 reset fault_valid", 32'(fault_valid), 0);
    rd(5'd0, 32'h0, "R11 reset control");
    rd(5'd17, 32'h0, "R11 reset attr0");
    rd(5'd30, 32'h0, "R11 reset base7");
    probe(32'h7000_0000, WR, 0, 0, 1, 0, -1, "R1 reset unit off");
  endtask

  task automatic t_disabled;
    set_rgn(0, 32'h4000_0000, mk_attr(1, 9, 0, 1, 8'h00));
    wr(5'd0, 32'h6);  // privdef + ctx, unit still off
    probe(32'h4000_0000, WR, 0, 0, 1, -1, -1, "R1 off, region no-access");
    probe(32'h4000_0000, FX, 0, 0, 1, -1, -1, "R1 off, xn fetch");
    probe(32'h7000_0000, RD, 0, 0, 1, -1, -1, "R1 off, miss");
  endtask

  task automatic t_readback;
    wr(5'd0, 32'hFFFF_FFFF);
    rd(5'd0, 32'h7, "R11 control mask");
    set_rgn(7, 32'h1234_5678, 32'hFFFF_FFFF);
    rd(5'd30, 32'h1234_5660, "R11 base low bits");
    rd(5'd31, 32'h1700_FF3F, "R11 attr field mask");
    set_rgn(7, 32'h0, 32'h0);
    rd(5'd31, 32'h0, "R11 attr cleared");
    wr(5'd0, 32'h1);
  endtask

  task automatic t_basic;
    set_rgn(1, 32'h2000_0000, mk_attr(1, 11, 3, 0, 8'h00));
    probe(32'h2000_0000, RD, 0, 0, 1, 1, 1, "R2 R12 low edge");
    probe(32'h2000_0FFC, WR, 0, 0, 1, 1, 1, "R2 R12 top of 4KB");
    probe(32'h2000_1000, RD, 0, 0, 0, 0, -1, "R2 just past window");
    probe(32'h1FFF_FFFC, RD, 0, 0, 0, 0, -1, "R2 just below window");
    set_rgn(2, 32'h3000_0000, mk_attr(1, 3, 3, 0, 8'h00));
    probe(32'h3000_0000, RD, 1, 0, 0, 0, -1, "R2 size code 3 never matches");
    set_rgn(2, 32'h3000_0000, mk_attr(1, 4, 3, 0, 8'h00));
    probe(32'h3000_001C, RD, 0, 0, 1, 1, 2, "R2 size code 4 is 32B");
    probe(32'h3000_0020, RD, 0, 0, 0, 0, -1, "R2 size code 4 end");
  endtask

  task automatic t_perm;
    logic [31:0] tbl;
    tbl = 32'h0510_F730;  // per code nibble: bit0 pr, bit1 pw, bit2 ur, bit3 uw
    for (int c = 0; c < 8; c++) begin
      set_rgn(0, 32'h4000_0000, mk_attr(1, 9, c, 0, 8'h00));
      for (int j = 0; j < 4; j++) begin
        bit p, w;
        p = (j < 2);
        w = (j % 2) == 1;
        probe(32'h4000_0100, w ? WR : RD, p, 0, tbl[c*4+j], 1, 0,
              $sformatf("R3 code %0d priv=%0d write=%0d", c, p, w));
      end
    end
  endtask

  task automatic t_xn;
    set_rgn(0, 32'h4000_0000, mk_attr(1, 9, 3, 1, 8'h00));
    probe(32'h4000_0040, FX, 1, 0, 0, 1, 0, "R4 xn fetch priv");
    probe(32'h4000_0040, RD, 0, 0, 1, 1, 0, "R4 xn read ok");
    set_rgn(0, 32'h4000_0000, mk_attr(1, 9, 3, 0, 8'h00));
    probe(32'h4000_0040, FX, 0, 0, 1, 1, 0, "R4 fetch without xn");
    set_rgn(0, 32'h4000_0000, mk_attr(1, 9, 1, 0, 8'h00));
    probe(32'h4000_0040, FX, 0, 0, 0, 1, 0, "R3 fetch needs user read");
  endtask

  task automatic t_sub;
    set_rgn(3, 32'h5000_0000, mk_attr(1, 9, 3, 0, 8'h04));
    probe(32'h5000_0100, RD, 0, 0, 0, 0, -1, "R5 hole start");
    probe(32'h5000_017C, RD, 0, 0, 0, 0, -1, "R5 hole end");
    probe(32'h5000_0180, RD, 0, 0, 1, 1, 3, "R5 after hole");
    probe(32'h5000_0080, RD, 0, 0, 1, 1, 3, "R5 before hole");
    set_rgn(3, 32'h5000_1000, mk_attr(1, 6, 3, 0, 8'hFF));
    probe(32'h5000_1040, RD, 0, 0, 1, 1, 3, "R5 128B ignores holes");
    set_rgn(3, 32'h5000_2000, mk_attr(1, 7, 3, 0, 8'h01));
    probe(32'h5000_2000, RD, 0, 0, 0, 0, -1, "R5 256B hole 0");
    probe(32'h5000_2020, RD, 0, 0, 1, 1, 3, "R5 256B sub 1");
  endtask

  task automatic t_overlap;
    set_rgn(4, 32'h6000_0000, mk_attr(1, 15, 3, 0, 8'h00));
    set_rgn(5, 32'h6000_0000, mk_attr(1, 11, 0, 0, 8'h00));
    set_rgn(6, 32'h6000_0000, mk_attr(1, 11, 6, 0, 8'h00));
    set_rgn(7, 32'h6000_0000, mk_attr(0, 15, 0, 0, 8'h00));
    probe(32'h6000_0010, WR, 0, 0, 0, 1, 6, "R6 top region read-only");
    probe(32'h6000_0010, RD, 0, 0, 1, 1, 6, "R6 top region read");
    probe(32'h6000_2000, WR, 0, 0, 1, 1, 4, "R6 only big region");
    wr(5'd31, mk_attr(1, 15, 0, 0, 8'h00));
    probe(32'h6000_2000, RD, 0, 0, 0, 1, 7, "R6 R9 region 7 enabled");
    wr(5'd31, mk_attr(0, 15, 0, 0, 8'h00));
    rd(5'd31, 32'h0000_001E, "R9 disabled keeps size");
    probe(32'h6000_2000, RD, 0, 0, 1, 1, 4, "R9 disabled ignored");
  endtask

  task automatic t_default;
    wr(5'd0, 32'h3);
    probe(32'h7000_0000, RD, 1, 0, 1, 0, -1, "R7 priv miss default map");
    probe(32'h7000_0000, RD, 0, 0, 0, 0, -1, "R7 user miss");
    wr(5'd0, 32'h1);
    probe(32'h7000_0000, RD, 1, 0, 0, 0, -1, "R7 priv miss no default");
  endtask

  task automatic t_ctx;
    wr(5'd0, 32'h1);
    probe(32'h7000_0000, RD, 0, 1, 1, -1, -1, "R8 ctx bypass miss");
    probe(32'h6000_0010, WR, 0, 1, 1, -1, -1, "R8 ctx bypass perm");
    wr(5'd0, 32'h5);
    probe(32'h7000_0000, RD, 0, 1, 0, 0, -1, "R8 ctx checked");
    probe(32'h7000_0000, RD, 0, 0, 0, 0, -1, "R8 normal ctx checked");
  endtask

  task automatic t_fault_reg;
    wr(5'd0, 32'h1);
    @(negedge clk);
    acc_valid = 1'b0; acc_addr = 32'h7000_0004; acc_kind = RD; acc_priv = 0; acc_fault_ctx = 0;
    @(negedge clk); #1;
    chk("R10 invalid access no fault", 32'(fault_valid), 0);
    probe(32'h7000_0004, RD, 0, 0, 0, 0, -1, "R10 capture");
    probe(32'h2000_0010, RD, 0, 0, 1, 1, 1, "R10 allowed after fault");
    chk("R10 fault_addr held", fault_addr, 32'h7000_0004);
  endtask

  task automatic t_enable;
    wr(5'd19, mk_attr(0, 11, 3, 0, 8'h00));
    probe(32'h2000_0FFC, RD, 0, 0, 0, 0, -1, "R9 region off");
    rd(5'd19, mk_attr(0, 11, 3, 0, 8'h00), "R9 fields kept");
    rd(5'd18, 32'h2000_0000, "R9 base kept");
    wr(5'd19, mk_attr(1, 11, 3, 0, 8'h00));
    probe(32'h2000_0FFC, RD, 0, 0, 1, 1, 1, "R9 region back on");
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    acc_valid = 1'b0; acc_addr = '0; acc_kind = '0; acc_priv = 1'b0; acc_fault_ctx = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_disabled();
    t_readback();
    t_basic();
    t_perm();
    t_xn();
    t_sub();
    t_overlap();
    t_default();
    t_ctx();
    t_fault_reg();
    t_enable();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL all watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule